// File: doc/BRIEF.md
# Word-Line Stress Fault Memory Model

This block is a bit-wide, single-port memory arranged as rows (word lines) by columns. It can carry one defective cell that behaves as a dynamic read-destructive cell. A March-test controller under development can be pointed at it in simulation, and the model gives that controller a realistic dynamic fault to find. When the fault is disabled, the array is an ideal synchronous RAM. A test sequence can therefore also be run against it to confirm that it reports no false failures.

The defective cell is chosen by a row, a column and a polarity. For polarity 0, the defect is armed by writing a 0 into the cell while it holds 1. For polarity 1, it is armed by writing a 1 while the cell holds 0. After the arming write, a counter records stresses. A stress is any access in the same row that is not a write to the defective cell. This includes reads of the defective cell itself and reads or writes of its row neighbours. When the count reaches the configured threshold, the cell inverts on that same clock edge.

Any of the following clears the count and drops the arm: an access to another row, a further write to the cell, or disabling the fault. Only an unbroken run of same-row accesses after the arming write can flip the cell.

Top module: `drdf_mem_emu`

## Requirements
- R1: Reset clears every cell to 0, holds `rd_vld` at 0 and holds `rd_data` at 0.
- R2: An access with `acc_en`=1 and `acc_we`=0 gives `rd_vld`=1 on the following cycle, with `rd_data` showing the cell's content after that edge. Any other cycle gives `rd_vld`=0.
- R3: With `flt_en`=0, every read returns the last value written to that cell, whatever the access pattern.
- R4: The fault arms only when a write stores the sensitizing value (`flt_pol`) into the faulty cell while that cell holds the opposite value. A write of the value the cell already holds does not arm it.
- R5: Once armed, each access to the faulty row counts one stress, unless it is a write to the faulty cell itself. At the stress whose number equals `flt_thresh` (1 to 7), the stored bit becomes the inverse of `flt_pol` on that edge. A neighbour write still updates the neighbour.
- R6: If the stress that reaches the threshold is a read of the faulty cell, that read returns the flipped value.
- R7: An access to any other row disarms the fault and clears the stress count.
- R8: A write to the faulty cell restarts the sequence. The write re-arms only under the R4 condition and otherwise leaves the fault disarmed.
- R9: A flipped cell keeps its wrong value through later reads and stresses until it is written again.
- R10: With `flt_pol`=1 (mirror), a 0-to-1 write arms the fault and the stored 1 flips to 0 at the threshold.
- R11: `flt_thresh`=0 never produces a flip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | 1 | Access strobe for this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_row | input | ROW_W | Row (word line) address |
| acc_col | input | COL_W | Column address |
| acc_wdata | input | 1 | Write data bit |
| rd_vld | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 1 | Read data bit |
| flt_en | input | 1 | Enables the emulated defect |
| flt_row | input | ROW_W | Row of the defective cell |
| flt_col | input | COL_W | Column of the defective cell |
| flt_pol | input | 1 | Sensitizing value: 0 primary, 1 mirror |
| flt_thresh | input | CNT_W | Stresses needed to flip, 0 = never |

## Verification
The bench aims at the exact stress on which the cell flips, in three cases:
- The threshold is reached by reads of the defective cell itself. A model that counts only neighbour accesses, or one that registers the flip a cycle late, would return the healthy value on that read.
- The run of stresses is broken by another-row access. A model that lets the count survive would flip the cell anyway.
- The run is restarted by a non-transition write. A model that arms on any write of the sensitizing value would flip the cell anyway.

Thresholds of 1, 3, 5 and 0, the mirror polarity, and the persistence of a flipped value until rewrite are each checked against fixed expected bits. Doing so separates a threshold that is off by one from a cell that recovers on its own.

// File: rtl/drdf_pkg.sv
package drdf_pkg;

    // How one access relates to the emulated defective cell.
    typedef enum logic [1:0] {
        ACC_IDLE      = 2'd0,   // no access this cycle
        ACC_OTHER_ROW = 2'd1,   // access on a different word line
        ACC_ROW_HIT   = 2'd2,   // access on the faulty word line (a stress)
        ACC_CELL_WR   = 2'd3    // write to the faulty cell itself
    } acc_kind_e;

endpackage

// File: rtl/drdf_cell_array.sv
module drdf_cell_array #(
    parameter int ROWS  = 8,
    parameter int COLS  = 16,
    parameter int ROW_W = $clog2(ROWS),
    parameter int COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [COL_W-1:0] wr_col,
    input  logic             wr_bit,
    input  logic             flip_en,
    input  logic [ROW_W-1:0] flip_row,
    input  logic [COL_W-1:0] flip_col,
    input  logic             flip_bit,
    input  logic [ROW_W-1:0] rd_row,
    input  logic [COL_W-1:0] rd_col,
    output logic             rd_bit,
    output logic             probe_bit
);

    logic [COLS-1:0] mem_w [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [COLS-1:0] row_d, row_q;

        always_comb begin
            row_d = row_q;
            if (wr_en && wr_row == ROW_W'(r)) begin
                row_d[wr_col] = wr_bit;
            end
            if (flip_en && flip_row == ROW_W'(r)) begin
                row_d[flip_col] = flip_bit;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                row_q <= '0;
            end else begin
                row_q <= row_d;
            end
        end

        assign mem_w[r] = row_q;
    end

    assign rd_bit    = mem_w[rd_row][rd_col];
    assign probe_bit = mem_w[flip_row][flip_col];

endmodule

// File: rtl/drdf_stress_tracker.sv
module drdf_stress_tracker
    import drdf_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fault_en,
    input  acc_kind_e        kind,
    input  logic             wr_bit,
    input  logic             cell_bit,
    input  logic             pol,
    input  logic [CNT_W-1:0] thresh,
    output logic             flip
);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } trk_s;

    trk_s             st_d, st_q;
    logic [CNT_W:0]   cnt_inc;

    always_comb begin
        st_d    = st_q;
        flip    = 1'b0;
        cnt_inc = {1'b0, st_q.cnt} + 1'b1;
        if (!fault_en) begin
            st_d = '0;
        end else begin
            unique case (kind)
                ACC_CELL_WR: begin
                    st_d.armed = (wr_bit == pol) && (cell_bit != pol);
                    st_d.cnt   = '0;
                end
                ACC_OTHER_ROW: begin
                    st_d = '0;
                end
                ACC_ROW_HIT: begin
                    if (st_q.armed) begin
                        if (thresh != '0 && cnt_inc == {1'b0, thresh}) begin
                            flip = 1'b1;
                            st_d = '0;
                        end else if (st_q.cnt != '1) begin
                            st_d.cnt = cnt_inc[CNT_W-1:0];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/drdf_mem_emu.sv
module drdf_mem_emu
    import drdf_pkg::*;
#(
    parameter int ROWS  = 8,
    parameter int COLS  = 16,
    parameter int CNT_W = 3,
    parameter int ROW_W = $clog2(ROWS),
    parameter int COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    input  logic             acc_we,
    input  logic [ROW_W-1:0] acc_row,
    input  logic [COL_W-1:0] acc_col,
    input  logic             acc_wdata,
    output logic             rd_vld,
    output logic             rd_data,
    input  logic             flt_en,
    input  logic [ROW_W-1:0] flt_row,
    input  logic [COL_W-1:0] flt_col,
    input  logic             flt_pol,
    input  logic [CNT_W-1:0] flt_thresh
);

    typedef struct packed {
        logic vld;
        logic data;
    } rd_s;

    acc_kind_e kind;
    logic      flip;
    logic      arr_bit;
    logic      probe_bit;
    rd_s       rd_d, rd_q;

    always_comb begin
        if (!acc_en) begin
            kind = ACC_IDLE;
        end else if (acc_row != flt_row) begin
            kind = ACC_OTHER_ROW;
        end else if (acc_we && acc_col == flt_col) begin
            kind = ACC_CELL_WR;
        end else begin
            kind = ACC_ROW_HIT;
        end
    end

    drdf_stress_tracker #(.CNT_W(CNT_W)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .fault_en (flt_en),
        .kind     (kind),
        .wr_bit   (acc_wdata),
        .cell_bit (probe_bit),
        .pol      (flt_pol),
        .thresh   (flt_thresh),
        .flip     (flip)
    );

    drdf_cell_array #(
        .ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)
    ) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (acc_en && acc_we),
        .wr_row    (acc_row),
        .wr_col    (acc_col),
        .wr_bit    (acc_wdata),
        .flip_en   (flip),
        .flip_row  (flt_row),
        .flip_col  (flt_col),
        .flip_bit  (~flt_pol),
        .rd_row    (acc_row),
        .rd_col    (acc_col),
        .rd_bit    (arr_bit),
        .probe_bit (probe_bit)
    );

    always_comb begin
        rd_d     = rd_q;
        rd_d.vld = acc_en && !acc_we;
        if (acc_en && !acc_we) begin
            // a read that is itself the flipping stress sees the new value
            rd_d.data = (flip && acc_col == flt_col) ? ~flt_pol : arr_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_vld  = rd_q.vld;
    assign rd_data = rd_q.data;

endmodule

// File: rtl/drdf_mem_emu_chk.sv
module drdf_mem_emu_chk #(
    parameter int ROW_W = 3,
    parameter int COL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_en,
    input logic             acc_we,
    input logic [ROW_W-1:0] acc_row,
    input logic [COL_W-1:0] acc_col,
    input logic             rd_vld,
    input logic             flt_en,
    input logic [ROW_W-1:0] flt_row,
    input logic [COL_W-1:0] flt_col,
    input logic             flt_pol,
    input logic             flip,
    input logic             probe_bit
);

    logic cell_wr;
    assign cell_wr = acc_en && acc_we && acc_row == flt_row && acc_col == flt_col;

    // R2: read valid follows a read strobe by exactly one cycle
    assert_rd_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> rd_vld == $past(acc_en && !acc_we));

    // R3: no flip while the defect is disabled
    assert_no_flip_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_en |-> !flip);

    // R5: a flip leaves the cell holding the inverse of the polarity
    assert_flip_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flip |=> (probe_bit == !$past(flt_pol)) || !$stable(flt_row) || !$stable(flt_col));

    // R5: flips only come from accesses on the faulty row
    assert_flip_in_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flip |-> acc_en && acc_row == flt_row);

    // R7: an access on another row blocks a flip in the next cycle
    assert_row_break_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_row != flt_row) |=> !flip);

    // R9: the faulty cell only changes through a write to it or a flip
    assert_cell_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cell_wr && !flip) |=> $stable(probe_bit) || !$stable(flt_row) || !$stable(flt_col));

endmodule

bind drdf_mem_emu drdf_mem_emu_chk #(.ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (acc_en),
    .acc_we    (acc_we),
    .acc_row   (acc_row),
    .acc_col   (acc_col),
    .rd_vld    (rd_vld),
    .flt_en    (flt_en),
    .flt_row   (flt_row),
    .flt_col   (flt_col),
    .flt_pol   (flt_pol),
    .flip      (flip),
    .probe_bit (probe_bit)
);

// File: tb/test_drdf_mem_emu.sv
module test_drdf_mem_emu;

    localparam int ROWS  = 8;
    localparam int COLS  = 16;
    localparam int CNT_W = 3;
    localparam int ROW_W = $clog2(ROWS);
    localparam int COL_W = $clog2(COLS);

    typedef struct {
        bit    exp;
        string tag;
    } item_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             acc_en = 1'b0, acc_we = 1'b0, acc_wdata = 1'b0;
    logic [ROW_W-1:0] acc_row = '0;
    logic [COL_W-1:0] acc_col = '0;
    logic             rd_vld, rd_data;
    logic             f_en = 1'b0, f_pol = 1'b0;
    logic [ROW_W-1:0] f_row = '0;
    logic [COL_W-1:0] f_col = '0;
    logic [CNT_W-1:0] f_thr = '0;

    int    checks = 0;
    int    failures = 0;
    item_t sb_q[$];
    string cur_tag = "R1";

    bit mdl [ROWS][COLS];
    bit m_armed = 1'b0;
    int m_cnt = 0;

    always #4 clk = ~clk;

    drdf_mem_emu #(.ROWS(ROWS), .COLS(COLS), .CNT_W(CNT_W)) i_drdf_mem_emu (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
        .acc_row(acc_row), .acc_col(acc_col), .acc_wdata(acc_wdata),
        .rd_vld(rd_vld), .rd_data(rd_data), .flt_en(f_en), .flt_row(f_row),
        .flt_col(f_col), .flt_pol(f_pol), .flt_thresh(f_thr)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference behaviour derived from R3..R11
    task automatic model_step(input bit we, input int r, input int c, input bit d,
                              output bit rv);
        bit sens = f_pol;
        if (!f_en || r != int'(f_row)) begin
            m_armed = 1'b0; m_cnt = 0;
        end else if (we && c == int'(f_col)) begin
            m_armed = (d == sens) && (mdl[r][c] != sens);
            m_cnt = 0;
        end else if (m_armed) begin
            if (m_cnt < 7) m_cnt++;
            if (f_thr != 0 && m_cnt == int'(f_thr)) begin
                mdl[f_row][f_col] = ~sens;
                m_armed = 1'b0; m_cnt = 0;
            end
        end
        if (we) mdl[r][c] = d;
        rv = mdl[r][c];
    endtask

    task automatic drive(input bit we, input int r, input int c, input bit d,
                         input bit use_fixed, input bit fixed);
        bit rv;
        item_t it;
        @(negedge clk);
        acc_en = 1'b1; acc_we = we; acc_row = ROW_W'(r); acc_col = COL_W'(c); acc_wdata = d;
        model_step(we, r, c, d, rv);
        if (!we) begin
            it.exp = use_fixed ? fixed : rv;
            it.tag = cur_tag;
            sb_q.push_back(it);
        end
    endtask

    task automatic wr(input int r, input int c, input bit d);
        drive(1'b1, r, c, d, 1'b0, 1'b0);
    endtask

    task automatic rd(input int r, input int c);
        drive(1'b0, r, c, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic rd_exp(input int r, input int c, input bit e);
        drive(1'b0, r, c, 1'b0, 1'b1, e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            acc_en = 1'b0; acc_we = 1'b0;
        end
    endtask

    task automatic set_fault(input bit en, input int r, input int c, input bit p, input int t);
        @(negedge clk);
        acc_en = 1'b0;
        f_en = en; f_row = ROW_W'(r); f_col = COL_W'(c); f_pol = p; f_thr = CNT_W'(t);
        m_armed = 1'b0; m_cnt = 0;
    endtask

    // Monitor: pops expected read data as results appear
    always @(negedge clk) begin
        if (rst_n && rd_vld) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R2 unexpected rd_vld", 1, 0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(rd_data === it.exp, it.tag, int'(rd_data), int'(it.exp));
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        foreach (mdl[r, c]) mdl[r][c] = 1'b0;
        repeat (4) @(negedge clk);
        check(rd_vld === 1'b0, "R1 rd_vld in reset", int'(rd_vld), 0);
        check(rd_data === 1'b0, "R1 rd_data in reset", int'(rd_data), 0);
        rst_n = 1'b1;
        cur_tag = "R1";
        rd_exp(0, 0, 1'b0); rd_exp(7, 15, 1'b0); rd_exp(3, 4, 1'b0);
        idle(2);
        check(rd_vld === 1'b0, "R2 rd_vld idle", int'(rd_vld), 0);

        // R3: defect configured but disabled
        set_fault(1'b0, 2, 5, 1'b0, 1);
        cur_tag = "R3";
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) wr(r, c, 1'((r * 3 + c) % 2));
        wr(2, 5, 1'b1); wr(2, 5, 1'b0); rd(2, 6); rd(2, 7);
        rd_exp(2, 5, 1'b0);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) rd(r, c);

        // R5/R6: primary polarity, threshold 3, flip on own read
        set_fault(1'b1, 3, 4, 1'b0, 3);
        cur_tag = "R6";
        wr(3, 4, 1'b1); wr(3, 4, 1'b0);
        rd(3, 0); wr(3, 9, 1'b1);
        rd_exp(3, 4, 1'b1);                       // third stress flips, read sees it
        cur_tag = "R9";
        rd_exp(3, 4, 1'b1); rd(6, 2); rd_exp(3, 4, 1'b1);
        cur_tag = "R5";
        rd_exp(3, 9, 1'b1);                       // neighbour write landed
        wr(3, 4, 1'b0);                           // 1 -> 0 re-arms
        rd_exp(3, 4, 1'b0); rd_exp(3, 4, 1'b0); rd_exp(3, 4, 1'b1);

        // R4: non-transition write leaves it disarmed
        cur_tag = "R4";
        wr(3, 4, 1'b0); wr(3, 4, 1'b0);
        for (int i = 0; i < 5; i++) rd(3, i);
        rd_exp(3, 4, 1'b0);

        // R7: another-row access breaks the run
        set_fault(1'b1, 3, 4, 1'b0, 2);
        cur_tag = "R7";
        wr(3, 4, 1'b1); wr(3, 4, 1'b0);
        rd(3, 1); rd(5, 1); rd(3, 2);
        rd_exp(3, 4, 1'b0);

        // R8: write to the cell restarts
        cur_tag = "R8";
        wr(3, 4, 1'b1); wr(3, 4, 1'b0);
        rd(3, 1); wr(3, 4, 1'b0); rd(3, 2);
        rd_exp(3, 4, 1'b0);

        // R5: threshold 1 and 5
        set_fault(1'b1, 3, 4, 1'b0, 1);
        cur_tag = "R5 thr1";
        wr(3, 4, 1'b1); wr(3, 4, 1'b0);
        rd_exp(3, 4, 1'b1);
        set_fault(1'b1, 3, 4, 1'b0, 5);
        cur_tag = "R5 thr5";
        wr(3, 4, 1'b0); wr(3, 4, 1'b1); wr(3, 4, 1'b0);
        wr(3, 10, 1'b0); wr(3, 11, 1'b1); wr(3, 12, 1'b0);
        rd_exp(3, 4, 1'b0); rd_exp(3, 4, 1'b1);

        // R10: mirror polarity
        set_fault(1'b1, 6, 15, 1'b1, 2);
        cur_tag = "R10";
        wr(6, 15, 1'b0); wr(6, 15, 1'b1);
        rd(6, 0); rd_exp(6, 15, 1'b0);
        rd_exp(6, 15, 1'b0);
        wr(6, 15, 1'b1); rd_exp(6, 15, 1'b1); rd_exp(6, 15, 1'b0);

        // R11: threshold 0 never flips
        set_fault(1'b1, 3, 4, 1'b0, 0);
        cur_tag = "R11";
        wr(3, 4, 1'b1); wr(3, 4, 1'b0);
        for (int i = 0; i < 9; i++) rd(3, 4 + (i % 2));
        rd_exp(3, 4, 1'b0);

        // full readback against the reference
        cur_tag = "R5 array";
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) rd(r, c);
        idle(3);
        check(sb_q.size() == 0, "R2 pending reads", sb_q.size(), 0);
        finish_run();
    end

endmodule